// File: doc/BRIEF.md
# Nine-Bit Receive Address Filter

This block sits between a serial receiver that hands over complete characters and the consumer of received data. It supports multidrop links in which one character in a frame carries an address and is marked by its top data bit. When software turns on address-filter mode, every completed character whose top data bit is 0 is discarded without a trace. A character whose top bit is 1 is forwarded as normal data, together with a receive interrupt pulse, so that software can decide whether the address belongs to this node.

The mode stays on until software writes the control word with the enable bit cleared. From then on, every character is forwarded. The position of the top data bit follows the configured character length. A character that is dropped by the filter never reports its framing error. A write to the control word applies from the next completed character on. The character that completes in the same cycle as the write is still judged under the old mode.

Top module: `rx_addr_filter`

## Requirements
- R1: After synchronous reset, `addr_mode`, `out_valid`, `out_frame_err` and `rx_irq` are all 0.
- R2: A control write (`ctl_we`=1) loads bit 2 of `ctl_wdata` into the filter mode, visible on `addr_mode` one cycle later. Other bits of the word have no effect on the mode.
- R3: With the mode off, every input character (`in_valid`=1) appears one cycle later on `out_valid`, with the same `out_data` and `out_frame_err` equal to `in_frame_err`.
- R4: With the mode on, a character whose top data bit is 0 gives no `out_valid` and no `rx_irq` in the following cycle.
- R5: With the mode on, a character whose top data bit is 1 is forwarded one cycle later with unchanged data and a one-cycle `rx_irq` pulse.
- R6: `cfg_len` selects the top data bit: 2'b00 gives 7-bit characters (bit 6), 2'b01 gives 8-bit (bit 7), 2'b10 and 2'b11 give 9-bit (bit 8).
- R7: A character that is dropped by the filter never raises `out_frame_err`, even if it arrived with `in_frame_err`=1.
- R8: A character that completes in the same cycle as a control write is judged under the mode held before that write.
- R9: The mode stays on through any number of characters, forwarded or dropped, until a control write clears bit 2.
- R10: `rx_irq` is high in exactly the cycles in which `out_valid` is high, and `out_valid` is 0 in the cycle after any cycle with `in_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 2 | Character length select (7, 8 or 9 bits) |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word; bit 2 is the filter enable |
| in_valid | input | 1 | A received character completes this cycle |
| in_data | input | 9 | Received character, right aligned |
| in_frame_err | input | 1 | Framing error flag of the received character |
| out_valid | output | 1 | Forwarded character valid |
| out_data | output | 9 | Forwarded character |
| out_frame_err | output | 1 | Framing error of the forwarded character |
| rx_irq | output | 1 | Receive interrupt pulse |
| addr_mode | output | 1 | Current filter mode |

## Verification
All results on the data side are due exactly one clock after the input cycle. These are the forwarded character, its error flag and the interrupt pulse. A control write shows on `addr_mode` one clock after the strobe. The bench drives every input on a falling edge and samples one time unit after the next rising edge, so each check reads the single register stage that the stimulus loaded. The sweep covers every 9-bit pattern and both error values under every length code and both modes. It then places control writes in the same cycle as a completing character to check which mode applies to which character.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int CHAR_W = 9;

    typedef enum logic [1:0] {
        LEN_7  = 2'b00,
        LEN_8  = 2'b01,
        LEN_9  = 2'b10,
        LEN_9B = 2'b11
    } char_len_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              ferr;
    } rx_char_t;

    // index of the marker bit for a given character length
    function automatic int marker_index(input char_len_e len);
        case (len)
            LEN_7:   return CHAR_W - 3;
            LEN_8:   return CHAR_W - 2;
            default: return CHAR_W - 1;
        endcase
    endfunction

    function automatic logic marker_bit(input char_len_e len,
                                        input logic [CHAR_W-1:0] data);
        return data[marker_index(len)];
    endfunction

endpackage

// File: rtl/rxaf_mode_reg.sv
module rxaf_mode_reg #(
    parameter int CTL_W  = 32,
    parameter int EN_BIT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output logic             mode
);
    logic ctl_unused;
    assign ctl_unused = ^wdata;

    always_ff @(posedge clk) begin
        if (rst)
            mode <= 1'b0;
        else if (we)
            mode <= wdata[EN_BIT];
    end
endmodule

// File: rtl/rxaf_judge.sv
module rxaf_judge
    import rxaf_pkg::*;
(
    input  logic      mode,
    input  char_len_e len,
    input  logic      in_valid,
    input  rx_char_t  in_char,
    output logic      keep
);
    logic marker;

    always_comb begin
        marker = marker_bit(len, in_char.data);
        keep   = in_valid && (!mode || marker);
    end
endmodule

// File: rtl/rxaf_out_stage.sv
module rxaf_out_stage
    import rxaf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     keep,
    input  rx_char_t in_char,
    output logic     out_valid,
    output rx_char_t out_char,
    output logic     irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            irq       <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= keep;
            irq       <= keep;
            if (keep)
                out_char <= in_char;
            else
                out_char.ferr <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
#(
    parameter int CTL_W  = 32,
    parameter int EN_BIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_len,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_frame_err,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    output logic              out_frame_err,
    output logic              rx_irq,
    output logic              addr_mode
);
    rx_char_t  cur_char;
    rx_char_t  fwd_char;
    char_len_e len_sel;
    logic      keep;

    assign cur_char = '{data: in_data, ferr: in_frame_err};
    assign len_sel  = char_len_e'(cfg_len);

    rxaf_mode_reg #(.CTL_W(CTL_W), .EN_BIT(EN_BIT)) u_mode (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .mode  (addr_mode)
    );

    rxaf_judge u_judge (
        .mode     (addr_mode),
        .len      (len_sel),
        .in_valid (in_valid),
        .in_char  (cur_char),
        .keep     (keep)
    );

    rxaf_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .keep      (keep),
        .in_char   (cur_char),
        .out_valid (out_valid),
        .out_char  (fwd_char),
        .irq       (rx_irq)
    );

    assign out_data      = fwd_char.data;
    assign out_frame_err = fwd_char.ferr;
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk
    import rxaf_pkg::*;
#(
    parameter int CTL_W  = 32,
    parameter int EN_BIT = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cfg_len,
    input logic              ctl_we,
    input logic [CTL_W-1:0]  ctl_wdata,
    input logic              in_valid,
    input logic [CHAR_W-1:0] in_data,
    input logic              in_frame_err,
    input logic              out_valid,
    input logic [CHAR_W-1:0] out_data,
    input logic              out_frame_err,
    input logic              rx_irq,
    input logic              addr_mode
);
    logic mk;
    assign mk = marker_bit(char_len_e'(cfg_len), in_data);

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) && !rst |-> !out_valid && !rx_irq && !addr_mode);

    a_r2_mode_load: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> addr_mode == $past(ctl_wdata[EN_BIT]));

    a_r3_pass_all: assert property (@(posedge clk) disable iff (rst)
        !addr_mode && in_valid |=> out_valid && out_data == $past(in_data)
                                  && out_frame_err == $past(in_frame_err));

    a_r4_drop_data: assert property (@(posedge clk) disable iff (rst)
        addr_mode && in_valid && !mk |=> !out_valid && !rx_irq);

    a_r5_pass_addr: assert property (@(posedge clk) disable iff (rst)
        addr_mode && in_valid && mk |=> out_valid && rx_irq
                                       && out_data == $past(in_data));

    a_r7_err_only_fwd: assert property (@(posedge clk) disable iff (rst)
        out_frame_err |-> out_valid);

    a_r9_mode_holds: assert property (@(posedge clk) disable iff (rst)
        addr_mode && !ctl_we |=> addr_mode);

    a_r10_irq_match: assert property (@(posedge clk) disable iff (rst)
        rx_irq == out_valid);

    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.CTL_W(CTL_W), .EN_BIT(EN_BIT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_len       (cfg_len),
    .ctl_we        (ctl_we),
    .ctl_wdata     (ctl_wdata),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_frame_err  (in_frame_err),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_frame_err (out_frame_err),
    .rx_irq        (rx_irq),
    .addr_mode     (addr_mode)
);

// File: tb/rx_addr_filter_test.sv
`timescale 1ns/1ps
module rx_addr_filter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_len = 2'b00;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        in_valid = 1'b0;
    logic [8:0]  in_data = '0;
    logic        in_frame_err = 1'b0;
    logic        out_valid;
    logic [8:0]  out_data;
    logic        out_frame_err;
    logic        rx_irq;
    logic        addr_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rx_addr_filter uut (
        .clk(clk), .rst(rst), .cfg_len(cfg_len), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .in_valid(in_valid), .in_data(in_data),
        .in_frame_err(in_frame_err), .out_valid(out_valid),
        .out_data(out_data), .out_frame_err(out_frame_err),
        .rx_irq(rx_irq), .addr_mode(addr_mode)
    );

    task automatic check(string req, logic [11:0] act, logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int top_pos(logic [1:0] len);
        return (len == 2'b00) ? 6 : (len == 2'b01) ? 7 : 8;
    endfunction

    // one cycle: drive at negedge, sample 1 ns after the next posedge
    task automatic step(bit v, logic [8:0] d, bit e, bit we, logic [31:0] wd,
                        bit exp_mode_before, string req);
        bit pass;
        @(negedge clk);
        in_valid = v; in_data = d; in_frame_err = e;
        ctl_we = we; ctl_wdata = wd;
        pass = v && (!exp_mode_before || d[top_pos(cfg_len)]);
        @(posedge clk); #1;
        check(req, {out_valid, rx_irq, out_frame_err, out_valid ? out_data : 9'h0},
                   {pass, pass, pass & e, pass ? d : 9'h0});
        @(negedge clk);
        in_valid = 0; ctl_we = 0;
    endtask

    task automatic set_mode(logic [31:0] wd, string req);
        @(negedge clk);
        ctl_we = 1; ctl_wdata = wd;
        @(posedge clk); #1;
        check(req, {11'h0, addr_mode}, {11'h0, wd[2]});
        @(negedge clk);
        ctl_we = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        // R1 reset state
        check("R1", {out_valid, rx_irq, out_frame_err, addr_mode}, 12'h0);

        // R2: other bits do not set the mode; bit 2 does
        set_mode(32'hFFFF_FFFB, "R2");
        set_mode(32'h0000_0004, "R2");
        set_mode(32'h0000_0000, "R2");

        // sweep: R3 R4 R5 R6 R7 R10
        for (int l = 0; l < 4; l++) begin
            cfg_len = l[1:0];
            for (int m = 0; m < 2; m++) begin
                set_mode(m ? 32'h4 : 32'h0, "R2");
                for (int d = 0; d < 512; d++) begin
                    for (int e = 0; e < 2; e++) begin
                        step(1'b1, d[8:0], e[0], 1'b0, 32'h0, m[0],
                             m ? "R4/R5/R6/R7" : "R3/R6");
                    end
                end
                step(1'b0, 9'h1FF, 1'b1, 1'b0, 32'h0, m[0], "R10");
            end
        end

        // R9: mode survives forwarded and dropped characters
        cfg_len = 2'b10;
        set_mode(32'h4, "R2");
        step(1'b1, 9'h100, 1'b0, 1'b0, 32'h0, 1'b1, "R9");
        step(1'b1, 9'h055, 1'b1, 1'b0, 32'h0, 1'b1, "R9");
        #1 check("R9", {11'h0, addr_mode}, 12'h1);

        // R8: clear coincides with a data character -> still dropped
        step(1'b1, 9'h0AA, 1'b1, 1'b1, 32'h0, 1'b1, "R8");
        step(1'b1, 9'h0AA, 1'b1, 1'b0, 32'h0, 1'b0, "R8");
        // R8: set coincides with a data character -> still forwarded
        step(1'b1, 9'h033, 1'b0, 1'b1, 32'h4, 1'b0, "R8");
        step(1'b1, 9'h033, 1'b0, 1'b0, 32'h0, 1'b1, "R8");
        #1 check("R8", {11'h0, addr_mode}, 12'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule